// File: doc/BRIEF.md
# ISA Plug-and-Play Card Configuration Controller

This block is the card-level configuration controller of an ISA plug-and-play expansion card. Configuration software reaches it through three byte-wide I/O ports. A fixed index port selects a configuration register. A fixed write port stores data into the selected register. A read port, which software can relocate, returns data from it. After reset the card ignores every index and data write until software writes the unlock key sequence to the index port. The card then sleeps until a wake command addresses it by its card-select number (CSN).

A card woken with a zero wake byte takes part in serial isolation. Each bit of its 72-bit identifier is reported through a pair of reads. A card whose identifier bit is 0 listens to the bus and drops out of isolation when another card reports a 1. The surviving card receives a CSN and moves to configuration. In configuration, writes to per-device register indices are passed on to a per-device register file, and reads of those indices are answered from it. Resource-data fetching, logical-device address decoding and interrupt routing sit outside this block.

The bus strobes `io_wr` and `io_rd` are one-cycle pulses, one per ISA access, already synchronised to `clk`.

Top module: `pnp_card_fsm`

## Requirements
- R1: A synchronous reset puts the card in the wait-for-key state and clears the CSN, the logical device number, the read-port field and the index. State codes on `state_o` are: 0 wait-for-key, 1 sleep, 2 isolation, 3 configuration.
- R2: In wait-for-key, bytes written to the index port (I/O 0x279) are compared with an 8-bit LFSR sequence. The sequence starts at 0x6A and advances as next = {v[1]^v[0], v[7:1]}. The 32nd consecutive matching write moves the card to sleep, and the card stays in wait-for-key before that write. Outside wait-for-key, a write to the index port loads the register index.
- R3: A key write that does not match the expected byte restarts the comparison from 0x6A. A key that is broken by a wrong byte does not unlock the card.
- R4: Any access made while `aen` is high is ignored.
- R5: A write to the data port (I/O 0xA79) at index 0x03, in sleep, isolation or configuration, is a wake command. If the byte equals the CSN, the card enters isolation when the byte is 0 and configuration otherwise. If the byte differs from the CSN, the card goes to sleep. A matching wake restarts the identifier bit pointer at bit 0.
- R6: A write at index 0x00 sets the read-port field, but only in isolation. The read port answers reads at the 12-bit address {2'b00, field, 2'b11}.
- R7: In isolation, reads at index 0x01 step through the identifier from bit 0, two reads per bit. For a 1 bit the card drives 0x55 and then 0xAA. For a 0 bit it does not drive. After 72 pairs it drives nothing.
- R8: When the card's bit is 0 and the bus carries 0x55 on the first read of a pair and 0xAA on the second, the card goes to sleep.
- R9: A write at index 0x06 sets the CSN in isolation (and moves the card to configuration) or in configuration. In configuration, index 0x06 reads back the CSN.
- R10: In configuration, index 0x07 is a read/write logical device number, and index 0x05 reads as {7'b0, res_ready}.
- R11: A write at index 0x02 carries three commands that may be combined. Bit 0 pulses `cfg_reset` for one cycle. Bit 1 returns the card to wait-for-key and keeps the CSN. Bit 2 clears the CSN and the read-port field.
- R12: In configuration, a data-port write at an index of 0x08 or above raises `reg_wr` for one cycle, with `reg_idx` and `reg_wdata` valid. In configuration, reads at index 0x04 or at 0x08 and above return `dev_rdata`. In any other state, no forwarding takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | ISA I/O address |
| aen | input | 1 | Address enable; high marks an access to ignore |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_rd | input | 1 | One-cycle I/O read strobe |
| wdata | input | 8 | Write data byte |
| bus_sense | input | 8 | Data bus value seen during a read |
| sid | input | 72 | Serial identifier, bit 0 reported first |
| res_ready | input | 1 | Resource byte ready flag shown in the status register |
| dev_rdata | input | 8 | Read data from the per-device register file |
| rd_data | output | 8 | Byte to drive on a read of the read port |
| rd_en | output | 1 | The card drives `rd_data` on this read |
| state_o | output | 2 | Card state code |
| csn_o | output | 8 | Card-select number |
| ldn_o | output | 8 | Logical device number |
| rd_port_o | output | 8 | Read-port field (address bits 9..2) |
| reg_idx | output | 8 | Current register index |
| reg_wr | output | 1 | Write strobe to the per-device register file |
| reg_wdata | output | 8 | Write data to the per-device register file |
| cfg_reset | output | 1 | One-cycle pulse that resets the logical device configuration |

## Verification
A single write to the configuration-control index can carry more than one command, so the device-reset pulse and the return to wait-for-key can land in the same cycle. The bench writes 0x03 there while the card is in configuration. In the cycle after that write, it checks that `cfg_reset` is high, that the state code is 0 and that the CSN is unchanged. A similar clash arises inside isolation: the card's own bit pointer and the drop-out rule both act on the second read of a pair. The bench shows that a losing pair sends the card to sleep rather than to the next bit, and that the next wake starts again from bit 0.

// File: rtl/pnp_card_pkg.sv
package pnp_card_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_KEY = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_ISOLATE  = 2'd2,
    ST_CONFIG   = 2'd3
  } pnp_state_e;

  localparam logic [7:0] IX_RDPORT   = 8'h00;
  localparam logic [7:0] IX_ISOLATE  = 8'h01;
  localparam logic [7:0] IX_CTRL     = 8'h02;
  localparam logic [7:0] IX_WAKE     = 8'h03;
  localparam logic [7:0] IX_RESDATA  = 8'h04;
  localparam logic [7:0] IX_STATUS   = 8'h05;
  localparam logic [7:0] IX_CSN      = 8'h06;
  localparam logic [7:0] IX_LDN      = 8'h07;
  localparam logic [7:0] IX_DEV_BASE = 8'h08;

  localparam logic [7:0] ISO_FIRST  = 8'h55;
  localparam logic [7:0] ISO_SECOND = 8'hAA;

  function automatic logic [7:0] key_lfsr_next(input logic [7:0] v);
    return {v[1] ^ v[0], v[7:1]};
  endfunction

endpackage

// File: rtl/pnp_io_decode.sv
module pnp_io_decode #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_PORT  = 12'h279,
  parameter logic [ADDR_W-1:0] WDATA_PORT = 12'hA79
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              aen,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        rd_port,
  output logic              addr_wr,
  output logic              data_wr,
  output logic              data_rd
);
  localparam int HI_W = ADDR_W - 10;

  logic [ADDR_W-1:0] rd_addr;
  assign rd_addr = {{HI_W{1'b0}}, rd_port, 2'b11};

  assign addr_wr = io_wr && !aen && (bus_addr == ADDR_PORT);
  assign data_wr = io_wr && !aen && (bus_addr == WDATA_PORT);
  assign data_rd = io_rd && !aen && (bus_addr == rd_addr);
endmodule

// File: rtl/pnp_key_detect.sv
module pnp_key_detect #(
  parameter int         KEY_LEN  = 32,
  parameter logic [7:0] KEY_SEED = 8'h6A
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       armed,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       done
);
  import pnp_card_pkg::*;

  localparam int CW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(KEY_LEN - 1);

  logic [7:0]    lfsr_q;
  logic [CW-1:0] cnt_q;
  logic          match;

  assign match = (wdata == lfsr_q);
  assign done  = armed && wr && match && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      lfsr_q <= KEY_SEED;
      cnt_q  <= '0;
    end else if (wr) begin
      if (match && (cnt_q != LAST)) begin
        lfsr_q <= key_lfsr_next(lfsr_q);
        cnt_q  <= cnt_q + 1'b1;
      end else begin
        lfsr_q <= KEY_SEED;
        cnt_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/pnp_isolate.sv
module pnp_isolate #(
  parameter int SID_BITS = 72
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                step,
  input  logic [SID_BITS-1:0] sid,
  input  logic [7:0]          sense,
  output logic                cur_bit,
  output logic                exhausted,
  output logic                second,
  output logic                lose
);
  import pnp_card_pkg::*;

  localparam int PW = $clog2(SID_BITS + 1);

  logic [PW-1:0]       ptr_q;
  logic                phase_q;
  logic                lost_q;
  logic [SID_BITS-1:0] shifted;

  assign shifted   = sid >> ptr_q;
  assign exhausted = (ptr_q == PW'(SID_BITS));
  assign cur_bit   = !exhausted && shifted[0];
  assign second    = phase_q;
  assign lose      = step && !exhausted && phase_q && lost_q && !cur_bit
                     && (sense == ISO_SECOND);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ptr_q   <= '0;
      phase_q <= 1'b0;
      lost_q  <= 1'b0;
    end else if (step && !exhausted) begin
      if (!phase_q) begin
        phase_q <= 1'b1;
        lost_q  <= !cur_bit && (sense == ISO_FIRST);
      end else begin
        phase_q <= 1'b0;
        lost_q  <= 1'b0;
        ptr_q   <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pnp_card_fsm.sv
module pnp_card_fsm #(
  parameter int ADDR_W   = 12,
  parameter int SID_BITS = 72,
  parameter int KEY_LEN  = 32,
  parameter logic [7:0] KEY_SEED = 8'h6A,
  parameter logic [ADDR_W-1:0] ADDR_PORT  = 12'h279,
  parameter logic [ADDR_W-1:0] WDATA_PORT = 12'hA79
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                aen,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [7:0]          wdata,
  input  logic [7:0]          bus_sense,
  input  logic [SID_BITS-1:0] sid,
  input  logic                res_ready,
  input  logic [7:0]          dev_rdata,
  output logic [7:0]          rd_data,
  output logic                rd_en,
  output logic [1:0]          state_o,
  output logic [7:0]          csn_o,
  output logic [7:0]          ldn_o,
  output logic [7:0]          rd_port_o,
  output logic [7:0]          reg_idx,
  output logic                reg_wr,
  output logic [7:0]          reg_wdata,
  output logic                cfg_reset
);
  import pnp_card_pkg::*;

  pnp_state_e state_q;
  logic [7:0] idx_q, csn_q, ldn_q, rdport_q, reg_wdata_q;
  logic       reg_wr_q, cfg_reset_q;

  logic addr_wr, data_wr, data_rd;
  logic key_done;
  logic iso_step, iso_restart, iso_bit, iso_exh, iso_second, iso_lose;
  logic active, wake_match;

  pnp_io_decode #(
    .ADDR_W(ADDR_W), .ADDR_PORT(ADDR_PORT), .WDATA_PORT(WDATA_PORT)
  ) u_dec (
    .bus_addr(bus_addr), .aen(aen), .io_wr(io_wr), .io_rd(io_rd),
    .rd_port(rdport_q), .addr_wr(addr_wr), .data_wr(data_wr), .data_rd(data_rd)
  );

  pnp_key_detect #(.KEY_LEN(KEY_LEN), .KEY_SEED(KEY_SEED)) u_key (
    .clk(clk), .rst(rst), .armed(state_q == ST_WAIT_KEY),
    .wr(addr_wr), .wdata(wdata), .done(key_done)
  );

  assign active      = (state_q != ST_WAIT_KEY);
  assign wake_match  = data_wr && active && (idx_q == IX_WAKE) && (wdata == csn_q);
  assign iso_restart = wake_match;
  assign iso_step    = data_rd && (state_q == ST_ISOLATE) && (idx_q == IX_ISOLATE);

  pnp_isolate #(.SID_BITS(SID_BITS)) u_iso (
    .clk(clk), .rst(rst), .restart(iso_restart), .step(iso_step),
    .sid(sid), .sense(bus_sense), .cur_bit(iso_bit), .exhausted(iso_exh),
    .second(iso_second), .lose(iso_lose)
  );

  // State and card control registers
  always_ff @(posedge clk) begin
    reg_wr_q    <= 1'b0;
    cfg_reset_q <= 1'b0;
    if (rst) begin
      state_q     <= ST_WAIT_KEY;
      idx_q       <= '0;
      csn_q       <= '0;
      ldn_q       <= '0;
      rdport_q    <= '0;
      reg_wdata_q <= '0;
    end else begin
      if (key_done) state_q <= ST_SLEEP;
      if (addr_wr && active) idx_q <= wdata;
      if (iso_lose) state_q <= ST_SLEEP;
      if (data_wr && active) begin
        case (idx_q)
          IX_RDPORT: if (state_q == ST_ISOLATE) rdport_q <= wdata;
          IX_CTRL: begin
            if (wdata[0]) cfg_reset_q <= 1'b1;
            if (wdata[2]) begin
              csn_q    <= '0;
              rdport_q <= '0;
            end
            if (wdata[1]) state_q <= ST_WAIT_KEY;
          end
          IX_WAKE: begin
            if (wdata == csn_q)
              state_q <= (wdata == 8'h00) ? ST_ISOLATE : ST_CONFIG;
            else
              state_q <= ST_SLEEP;
          end
          IX_CSN: begin
            if (state_q == ST_ISOLATE) begin
              csn_q   <= wdata;
              state_q <= ST_CONFIG;
            end else if (state_q == ST_CONFIG) begin
              csn_q <= wdata;
            end
          end
          IX_LDN: if (state_q == ST_CONFIG) ldn_q <= wdata;
          default: begin
            if ((state_q == ST_CONFIG) && (idx_q >= IX_DEV_BASE)) begin
              reg_wr_q    <= 1'b1;
              reg_wdata_q <= wdata;
            end
          end
        endcase
      end
    end
  end

  // Read-port response
  always_comb begin
    rd_en   = 1'b0;
    rd_data = 8'h00;
    if (data_rd) begin
      if (state_q == ST_ISOLATE) begin
        if ((idx_q == IX_ISOLATE) && !iso_exh && iso_bit) begin
          rd_en   = 1'b1;
          rd_data = iso_second ? ISO_SECOND : ISO_FIRST;
        end
      end else if (state_q == ST_CONFIG) begin
        case (idx_q)
          IX_RDPORT, IX_ISOLATE, IX_CTRL, IX_WAKE: rd_en = 1'b0;
          IX_STATUS: begin
            rd_en   = 1'b1;
            rd_data = {7'b0, res_ready};
          end
          IX_CSN: begin
            rd_en   = 1'b1;
            rd_data = csn_q;
          end
          IX_LDN: begin
            rd_en   = 1'b1;
            rd_data = ldn_q;
          end
          default: begin
            rd_en   = 1'b1;
            rd_data = dev_rdata;
          end
        endcase
      end
    end
  end

  assign state_o   = state_q;
  assign csn_o     = csn_q;
  assign ldn_o     = ldn_q;
  assign rd_port_o = rdport_q;
  assign reg_idx   = idx_q;
  assign reg_wr    = reg_wr_q;
  assign reg_wdata = reg_wdata_q;
  assign cfg_reset = cfg_reset_q;
endmodule

// File: rtl/pnp_card_fsm_chk.sv
module pnp_card_fsm_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_PORT  = 12'h279,
  parameter logic [ADDR_W-1:0] WDATA_PORT = 12'hA79
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              aen,
  input logic              io_wr,
  input logic [7:0]        wdata,
  input logic [1:0]        state_o,
  input logic [7:0]        csn_o,
  input logic [7:0]        rd_port_o,
  input logic [7:0]        idx_q,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              reg_wr,
  input logic [7:0]        reg_idx,
  input logic              cfg_reset
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (state_o == 2'd0 && csn_o == 8'h00 && rd_port_o == 8'h00 && !reg_wr)); // R1

  AST_KEY_NEEDS_INDEX_WRITE: assert property (@(posedge clk) disable iff (rst)
    ($past(state_o) == 2'd0 && state_o == 2'd1)
      |-> $past(io_wr && !aen && bus_addr == ADDR_PORT)); // R2

  AST_AEN_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    $past(aen && !rst) |-> (state_o == $past(state_o) && csn_o == $past(csn_o))); // R4

  AST_WAKE_ZERO_ISOLATES: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !aen && bus_addr == WDATA_PORT && state_o == 2'd1 && idx_q == 8'h03
     && wdata == 8'h00 && csn_o == 8'h00) |=> (state_o == 2'd2)); // R5

  AST_RDPORT_ONLY_ISOLATE: assert property (@(posedge clk) disable iff (rst)
    (rd_port_o != $past(rd_port_o)) |-> ($past(state_o) == 2'd2 || rd_port_o == 8'h00)); // R6

  AST_ISO_PATTERN: assert property (@(posedge clk) disable iff (rst)
    (rd_en && state_o == 2'd2) |-> (rd_data == 8'h55 || rd_data == 8'hAA)); // R7

  AST_CFGRST_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    cfg_reset |-> $past(io_wr && !aen && bus_addr == WDATA_PORT && wdata[0])); // R11

  AST_REGWR_ONLY_CONFIG: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> ($past(state_o) == 2'd3 && reg_idx >= 8'h08)); // R12
endmodule

bind pnp_card_fsm pnp_card_fsm_chk #(
  .ADDR_W(ADDR_W), .ADDR_PORT(ADDR_PORT), .WDATA_PORT(WDATA_PORT)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .aen(aen), .io_wr(io_wr),
  .wdata(wdata), .state_o(state_o), .csn_o(csn_o), .rd_port_o(rd_port_o),
  .idx_q(idx_q), .rd_en(rd_en), .rd_data(rd_data), .reg_wr(reg_wr),
  .reg_idx(reg_idx), .cfg_reset(cfg_reset)
);

// File: tb/pnp_card_fsm_bench.sv
module pnp_card_fsm_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_INDEX = 12'h279;
  localparam logic [11:0] A_WDATA = 12'hA79;
  localparam logic [71:0] SID_VAL = 72'h00_1234_5678_9ABC_DE96;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        aen = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  wdata = '0, bus_sense = '0, dev_rdata = 8'hC3;
  logic        res_ready = 1'b1;
  logic [7:0]  rd_data, csn_o, ldn_o, rd_port_o, reg_idx, reg_wdata;
  logic        rd_en, reg_wr, cfg_reset;
  logic [1:0]  state_o;
  logic [11:0] rd_addr = 12'h003;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pnp_card_fsm u_pnp_card_fsm (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .aen(aen), .io_wr(io_wr),
    .io_rd(io_rd), .wdata(wdata), .bus_sense(bus_sense), .sid(SID_VAL),
    .res_ready(res_ready), .dev_rdata(dev_rdata), .rd_data(rd_data),
    .rd_en(rd_en), .state_o(state_o), .csn_o(csn_o), .ldn_o(ldn_o),
    .rd_port_o(rd_port_o), .reg_idx(reg_idx), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .cfg_reset(cfg_reset)
  );

  function automatic logic [7:0] lfsr_step(input logic [7:0] v);
    return {v[1] ^ v[0], v[7:1]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d, input logic en_aen = 1'b0);
    @(negedge clk);
    bus_addr = a; wdata = d; io_wr = 1'b1; aen = en_aen;
    @(negedge clk);
    io_wr = 1'b0; aen = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
    bus_write(A_INDEX, idx);
    bus_write(A_WDATA, d);
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [7:0] sense,
                          output logic [7:0] d, output logic en);
    @(negedge clk);
    bus_addr = a; io_rd = 1'b1; bus_sense = sense;
    #1;
    d = rd_data; en = rd_en;
    @(negedge clk);
    io_rd = 1'b0; bus_sense = 8'h00;
  endtask

  task automatic send_key(input int count, input bit check_steps);
    logic [7:0] k = 8'h6A;
    for (int i = 0; i < count; i++) begin
      if (check_steps && i == 31) check("R2 state before last key byte", state_o, 2'd0);
      bus_write(A_INDEX, k);
      k = lfsr_step(k);
    end
  endtask

  task automatic t_reset;
    check("R1 state after reset", state_o, 2'd0);
    check("R1 csn after reset", csn_o, 8'h00);
    check("R1 ldn after reset", ldn_o, 8'h00);
    check("R1 read port after reset", rd_port_o, 8'h00);
    check("R1 no reg_wr after reset", reg_wr, 1'b0);
  endtask

  task automatic t_key;
    logic [7:0] k = 8'h6A;
    for (int i = 0; i < 10; i++) begin bus_write(A_INDEX, k); k = lfsr_step(k); end
    bus_write(A_INDEX, 8'h00);
    for (int i = 10; i < 32; i++) begin bus_write(A_INDEX, k); k = lfsr_step(k); end
    check("R3 broken key keeps wait-for-key", state_o, 2'd0);
    send_key(32, 1'b1);
    check("R2 full key reaches sleep", state_o, 2'd1);
  endtask

  task automatic t_wake_aen;
    bus_write(A_INDEX, 8'h03);
    bus_write(A_WDATA, 8'h00, 1'b1);
    check("R4 wake with aen ignored", state_o, 2'd1);
    bus_write(A_WDATA, 8'h00);
    check("R5 wake zero enters isolation", state_o, 2'd2);
  endtask

  task automatic t_isolate;
    logic [7:0] d; logic en; int errs;
    set_reg(8'h00, 8'h80);
    check("R6 read port set in isolation", rd_port_o, 8'h80);
    rd_addr = 12'h203;
    bus_write(A_INDEX, 8'h01);
    bus_read(12'h207, 8'h00, d, en);
    check("R6 other address not answered", en, 1'b0);
    // bit0 = 0: no drive, nobody else drives
    bus_read(rd_addr, 8'h00, d, en); check("R7 zero bit first read not driven", en, 1'b0);
    bus_read(rd_addr, 8'h00, d, en);
    // bit1 = 1
    bus_read(rd_addr, 8'h55, d, en); check("R7 one bit first read", {en, d}, {1'b1, 8'h55});
    bus_read(rd_addr, 8'hAA, d, en); check("R7 one bit second read", {en, d}, {1'b1, 8'hAA});
    bus_read(rd_addr, 8'h55, d, en); bus_read(rd_addr, 8'hAA, d, en);
    // bit3 = 0 while another card reports 1
    bus_read(rd_addr, 8'h55, d, en);
    check("R8 still isolating after first read", state_o, 2'd2);
    bus_read(rd_addr, 8'hAA, d, en);
    check("R8 losing card sleeps", state_o, 2'd1);
    set_reg(8'h03, 8'h00);
    check("R5 re-wake enters isolation", state_o, 2'd2);
    bus_write(A_INDEX, 8'h01);
    errs = 0;
    for (int i = 0; i < 72; i++) begin
      bus_read(rd_addr, SID_VAL[i] ? 8'h55 : 8'h00, d, en);
      if (en !== SID_VAL[i] || (en && d !== 8'h55)) errs++;
      bus_read(rd_addr, SID_VAL[i] ? 8'hAA : 8'h00, d, en);
      if (en !== SID_VAL[i] || (en && d !== 8'hAA)) errs++;
    end
    check("R7 full identifier from bit 0 after wake", errs, 0);
    bus_read(rd_addr, 8'h00, d, en);
    check("R7 no drive after 72 pairs", en, 1'b0);
    bus_write(A_INDEX, 8'h30);
    bus_write(A_WDATA, 8'h11);
    check("R12 no forwarding in isolation", reg_wr, 1'b0);
    set_reg(8'h06, 8'h05);
    check("R9 csn write in isolation", {state_o, csn_o}, {2'd3, 8'h05});
  endtask

  task automatic t_config;
    logic [7:0] d; logic en;
    bus_write(A_INDEX, 8'h06);
    bus_read(rd_addr, 8'h00, d, en);
    check("R9 csn read back", {en, d}, {1'b1, 8'h05});
    set_reg(8'h00, 8'h40);
    check("R6 read port write ignored in config", rd_port_o, 8'h80);
    bus_write(A_INDEX, 8'h07);
    bus_write(A_WDATA, 8'h01);
    check("R12 no forwarding for index 7", reg_wr, 1'b0);
    bus_read(rd_addr, 8'h00, d, en);
    check("R10 ldn read back", {en, d}, {1'b1, 8'h01});
    bus_write(A_INDEX, 8'h05);
    bus_read(rd_addr, 8'h00, d, en);
    check("R10 status shows res_ready", {en, d}, {1'b1, 8'h01});
    bus_write(A_INDEX, 8'h30);
    bus_write(A_WDATA, 8'h5A);
    check("R12 forwarded write", {reg_wr, reg_idx, reg_wdata}, {1'b1, 8'h30, 8'h5A});
    @(negedge clk);
    check("R12 reg_wr lasts one cycle", reg_wr, 1'b0);
    bus_read(rd_addr, 8'h00, d, en);
    check("R12 device read data", {en, d}, {1'b1, 8'hC3});
    set_reg(8'h03, 8'h09);
    check("R5 mismatched wake sleeps", state_o, 2'd1);
    set_reg(8'h03, 8'h05);
    check("R5 matching nonzero wake configures", state_o, 2'd3);
  endtask

  task automatic t_control;
    set_reg(8'h02, 8'h01);
    check("R11 device reset pulse", {cfg_reset, state_o}, {1'b1, 2'd3});
    @(negedge clk);
    check("R11 device reset one cycle", cfg_reset, 1'b0);
    bus_write(A_WDATA, 8'h03);
    check("R11 reset and wait-for-key together", {cfg_reset, state_o, csn_o}, {1'b1, 2'd0, 8'h05});
    send_key(32, 1'b0);
    set_reg(8'h03, 8'h05);
    check("R5 wake after rekey", state_o, 2'd3);
    set_reg(8'h02, 8'h04);
    check("R11 csn and read port cleared", {state_o, csn_o, rd_port_o}, {2'd3, 8'h00, 8'h00});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_key();
    t_wake_aen();
    t_isolate();
    t_config();
    t_control();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule